// File: doc/BRIEF.md
# Lane-Confined Byte Shifter

This unit moves the bytes of a wide vector left or right by a whole number of byte positions. The vector is split into equal lanes (two lanes of sixteen bytes by default). Each lane is shifted on its own by the same byte count. A byte never moves from one lane into the other. Positions left empty by the shift take zero bytes.

The count is an unsigned byte amount. Any count larger than the last byte index of a lane clears the whole result rather than wrapping. A single direction input chooses the way the bytes move.

By default the result is registered. In that case a valid flag travels with it and arrives one cycle after the input flag. A parameter removes the register and makes the unit purely combinational.

Top module: `lane_byte_shifter`

## Requirements
- R1: No byte crosses a lane boundary. After a left shift the lowest bytes of the upper lane are zero; after a right shift the highest bytes of the lower lane are zero. Neither takes bytes from the neighbouring lane.
- R2: With `dir_right` = 0 (left) and count n in 1..15, byte i of each lane becomes byte i-n of the same lane. If i < n, the byte is zero. Byte 0 is the least significant byte (bits 7:0) of its lane.
- R3: With `dir_right` = 1 (right) and count n in 1..15, byte i of each lane becomes byte i+n of the same lane. If i+n > 15, the byte is zero.
- R4: Any count from 16 to 255 gives an all-zero 256-bit result in both directions.
- R5: A count of 0 returns the operand unchanged in both directions.
- R6: In the registered configuration, `out_valid` equals `in_valid` one cycle later. The matching `result` is visible in that same cycle.
- R7: While `in_valid` is low, `result` holds its last value. Changes on `operand`, `count` and `dir_right` have no effect on it.
- R8: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies operand, count and direction |
| operand | input | 256 | Vector to shift; lane k occupies bits 128k+127:128k |
| count | input | 8 | Unsigned shift amount in bytes |
| dir_right | input | 1 | 0 shifts toward higher byte indices, 1 toward lower |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| result | output | 256 | Shifted vector |

## Verification
Every result of the registered unit is due exactly one rising edge after its inputs are accepted. The bench therefore drives each input on a falling edge and compares `result` and `out_valid` on the next falling edge, half a period after the capturing edge. The idle-hold check drops `in_valid` and disturbs the data inputs for several cycles. It then reads the held result at falling edges and compares it with the value of the last accepted vector. Reset values are sampled at a falling edge while reset is still asserted.

// File: rtl/lane_byte_shifter.sv
module lane_byte_shifter #(
  parameter int LANES      = 2,
  parameter int LANE_BYTES = 16,
  parameter int CNT_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [LANES*LANE_BYTES*8-1:0] operand,
  input  logic [CNT_W-1:0]              count,
  input  logic                          dir_right,
  output logic                          out_valid,
  output logic [LANES*LANE_BYTES*8-1:0] result
);
  localparam int LANE_W = LANE_BYTES * 8;
  localparam int VEC_W  = LANES * LANE_W;
  localparam int IDX_W  = $clog2(LANE_BYTES);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(LANE_BYTES - 1);

  logic             too_far;
  logic [IDX_W+2:0] bit_amt;
  logic [VEC_W-1:0] shifted;

  assign too_far = count > MAX_CNT;
  assign bit_amt = {count[IDX_W-1:0], 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] src;
    assign src = operand[g*LANE_W +: LANE_W];
    assign shifted[g*LANE_W +: LANE_W] =
      too_far   ? '0 :
      dir_right ? (src >> bit_amt) : (src << bit_amt);
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) result <= shifted;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = shifted;
  end
endmodule

// File: rtl/lane_byte_shifter_chk.sv
module lane_byte_shifter_chk #(
  parameter int VEC_W      = 256,
  parameter int CNT_W      = 8,
  parameter int LANE_BYTES = 16,
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [VEC_W-1:0] operand,
  input logic [CNT_W-1:0] count,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(LANE_BYTES - 1);

  if (REGISTERED) begin : g_props
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R6
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result)); // R7
    AST_OVERRANGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && count > MAX_CNT) |=> result == '0); // R4
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && count == '0) |=> result == $past(operand)); // R5
  end
endmodule

bind lane_byte_shifter lane_byte_shifter_chk #(
  .VEC_W(VEC_W), .CNT_W(CNT_W), .LANE_BYTES(LANE_BYTES), .REGISTERED(REGISTERED)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
  .count(count), .out_valid(out_valid), .result(result)
);

// File: tb/lane_byte_shifter_tb_top.sv
module lane_byte_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;
  localparam int VW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] operand = '0;
  logic [7:0]    count = '0;
  logic          dir_right = 1'b0;
  logic          out_valid;
  logic [VW-1:0] result;
  int            n_chk = 0;
  int            n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_byte_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .count(count), .dir_right(dir_right), .out_valid(out_valid), .result(result)
  );

  function automatic logic [VW-1:0] model(logic [VW-1:0] v, int n, bit rt);
    logic [VW-1:0] r = '0;
    for (int lane = 0; lane < 2; lane++)
      for (int i = 0; i < 16; i++) begin
        int s = rt ? i + n : i - n;
        if (n <= 15 && s >= 0 && s <= 15)
          r[(lane*16+i)*8 +: 8] = v[(lane*16+s)*8 +: 8];
      end
    return r;
  endfunction

  function automatic logic [VW-1:0] pattern(int p);
    logic [VW-1:0] r;
    for (int b = 0; b < NB; b++)
      case (p)
        0: r[b*8 +: 8] = 8'(b + 1);
        1: r[b*8 +: 8] = 8'hA5 ^ 8'(b * 37);
        default: r[b*8 +: 8] = 8'hFF;
      endcase
    return r;
  endfunction

  task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [VW-1:0] v, int n, bit rt, output logic [VW-1:0] got);
    string tag;
    operand = v; count = 8'(n); dir_right = rt; in_valid = 1'b1;
    @(negedge clk);
    tag = (n == 0) ? "R5" : (n > 15) ? "R4" : rt ? "R3" : "R2";
    check(tag, result, model(v, n, rt));
    check("R6 valid", VW'(out_valid), VW'(1));
    got = result;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] got;
    repeat (3) @(negedge clk);
    check("R8 result", result, '0);
    check("R8 valid", VW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 idle valid", VW'(out_valid), '0);

    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 256; n++)
          apply(pattern(p), n, d[0], got);

    // R1: left shift of a full lower lane must not leak into the upper lane
    for (int n = 1; n < 16; n++) begin
      apply({128'h0, {128{1'b1}}}, n, 1'b0, got);
      check("R1 upper lane", VW'(got[255:128]), '0);
      apply({{128{1'b1}}, 128'h0}, n, 1'b1, got);
      check("R1 lower lane", VW'(got[127:0]), '0);
    end

    // R7: hold while idle
    apply(pattern(1), 5, 1'b0, got);
    in_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      operand = pattern(k % 3) ^ VW'(k * 7919);
      count = 8'(k);
      dir_right = k[0];
      @(negedge clk);
      check("R7 hold", result, model(pattern(1), 5, 1'b0));
      check("R6 no valid", VW'(out_valid), '0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule